// File: doc/BRIEF.md
# E1 CRC-4 Sub-Multiframe Checker with Per-Second Error Accumulation

This block sits behind an E1 framer. It sees the received bit stream one bit per cycle, qualified by a valid strobe. It also gets three kinds of position marker from the framer: the first bit of each sub-multiframe, the bit slots that carry CRC remainder bits, and a tick once per second. Over every sub-multiframe it runs a 4-bit CRC. The four remainder bits carried in the next sub-multiframe are then checked against that result, and each comparison and each mismatch is reported as a one-cycle pulse.

Mismatches are summed within each one-second interval. At every tick the total for the interval is moved into a holding register for a host to read, and the running count restarts. When the count within an interval reaches a fixed threshold, an excessive-error flag is raised. If the enable input is set, a single-cycle request for a fresh frame search is also issued.

Top module: `e1_crc4_mon`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `crc_chk`, `crc_err`, `err_hold`, `excess` and `search_req` are all zero.
- R2: The CRC is the remainder of M(x)·x^4 modulo x^4 + x + 1. M(x) is built from the valid bits of one sub-multiframe, with the earliest bit as the highest-degree coefficient. Every bit flagged by `rem_mark` counts as zero in M(x).
- R3: In each sub-multiframe, the first four valid bits flagged by `rem_mark` form the received remainder, and the first of them is the most significant bit. When the fourth one arrives, the remainder is compared with the CRC of the preceding sub-multiframe. `crc_chk` pulses on the next cycle, and `crc_err` pulses with it when the two differ.
- R4: No comparison is made inside the first sub-multiframe that starts after reset or after a `realign` pulse, and none is made on the cycle after `realign`.
- R5: A cycle with `rx_valid` low has no effect on the CRC, the remainder capture or the markers, whatever `rx_data`, `smf_mark` and `rem_mark` carry.
- R6: On a `sec_tick` cycle, `err_hold` takes the interval's mismatch count, including a mismatch pulse on that same cycle, and the running count restarts from zero. At all other times `err_hold` holds its value.
- R7: The running count saturates at 2^CNT_W − 1 rather than wrapping.
- R8: `excess` rises on the cycle after the running count reaches THRESH. It stays high until it is cleared on the next `sec_tick`. An interval with fewer than THRESH mismatches leaves it low.
- R9: `search_req` is a single-cycle pulse that coincides with the rise of `excess`, and only when `search_en` is high on that cycle. So there is at most one pulse per interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Bit strobe: `rx_data` and the markers are meaningful |
| rx_data | input | 1 | Received E1 bit |
| smf_mark | input | 1 | Current bit is the first of a sub-multiframe |
| rem_mark | input | 1 | Current bit is a CRC remainder slot |
| sec_tick | input | 1 | One-second interval boundary |
| realign | input | 1 | Framer has realigned; discard CRC history |
| search_en | input | 1 | Allow frame-search requests on excessive errors |
| crc_chk | output | 1 | Pulse: a comparison was made |
| crc_err | output | 1 | Pulse: that comparison mismatched |
| err_hold | output | CNT_W | Mismatch total of the previous interval |
| excess | output | 1 | Threshold reached in the current interval |
| search_req | output | 1 | Pulse: request a new frame search |

## Verification
The bench builds the block with CNT_W = 4 and THRESH = 5. A 15-value ceiling and a threshold of five mismatches can then be crossed, saturated and undershot within a few dozen short sub-multiframes. It drives 32-bit sub-multiframes whose remainder slots sit at every eighth bit. This makes it practical to sweep all sixteen possible received remainders against one fixed payload, and a walking-one payload through every bit position. It also inserts idle strobe gaps that carry misleading data and markers.

// File: rtl/e1c4_pkg.sv
package e1c4_pkg;

    localparam int CRC_W = 4;
    localparam int IDX_W = $clog2(CRC_W);
    localparam logic [CRC_W-1:0] CRC_POLY_LOW = 4'b0011;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic vld;
        logic data;
        logic smf_start;
        logic rem_slot;
    } rx_bit_t;

    typedef struct packed {
        logic fire;
        logic mismatch;
    } cmp_evt_t;

    function automatic crc_t crc_step(crc_t c, logic d);
        logic fb;
        fb = c[CRC_W-1] ^ d;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY_LOW : '0);
    endfunction

endpackage

// File: rtl/e1c4_crc_engine.sv
module e1c4_crc_engine
    import e1c4_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_bit_t rx,
    input  logic    realign,
    output crc_t    prev_crc,
    output logic    prev_ok
);
    crc_t acc_q;
    logic started_q;
    logic din_eff;

    // remainder slots enter the polynomial as zero
    always_comb din_eff = rx.rem_slot ? 1'b0 : rx.data;

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            acc_q     <= '0;
            prev_crc  <= '0;
            prev_ok   <= 1'b0;
            started_q <= 1'b0;
        end else if (rx.vld) begin
            if (rx.smf_start) begin
                prev_crc  <= acc_q;
                prev_ok   <= started_q;
                started_q <= 1'b1;
                acc_q     <= crc_step('0, din_eff);
            end else begin
                acc_q <= crc_step(acc_q, din_eff);
            end
        end
    end

endmodule

// File: rtl/e1c4_rem_capture.sv
module e1c4_rem_capture
    import e1c4_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_bit_t  rx,
    input  logic     realign,
    input  crc_t     prev_crc,
    input  logic     prev_ok,
    output cmp_evt_t evt
);
    logic [IDX_W-1:0] idx_q, eff_idx;
    logic [CRC_W-2:0] sh_q;
    logic             done_q, eff_done;
    crc_t             rx_word;
    logic             take, last, fire;

    always_comb begin
        eff_idx  = rx.smf_start ? '0 : idx_q;
        eff_done = rx.smf_start ? 1'b0 : done_q;
        rx_word  = {sh_q, rx.data};
        take     = rx.vld && rx.rem_slot && !eff_done;
        last     = take && (eff_idx == IDX_W'(CRC_W - 1));
        fire     = last && prev_ok && !realign;
    end

    always_ff @(posedge clk) begin
        if (rst || realign) begin
            idx_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
            evt    <= '0;
        end else begin
            evt.fire     <= fire;
            evt.mismatch <= fire && (rx_word != prev_crc);
            if (take) begin
                sh_q   <= rx_word[CRC_W-2:0];
                idx_q  <= eff_idx + 1'b1;
                done_q <= last;
            end else if (rx.vld && rx.smf_start) begin
                idx_q  <= '0;
                done_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/e1c4_err_accum.sv
module e1c4_err_accum #(
    parameter int CNT_W  = 10,
    parameter int THRESH = 915
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_evt,
    input  logic             sec_tick,
    input  logic             search_en,
    output logic [CNT_W-1:0] hold,
    output logic             excess,
    output logic             search_req
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] THR     = CNT_W'(THRESH);

    if (THRESH < 1 || THRESH > (2 ** CNT_W) - 1) begin : g_bad_cfg
        $error("THRESH does not fit the counter width");
    end

    logic [CNT_W-1:0] live_q, inc;
    logic             reach;

    always_comb begin
        inc   = (live_q == CNT_MAX) ? live_q
                                    : live_q + {{(CNT_W-1){1'b0}}, err_evt};
        reach = (inc >= THR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q     <= '0;
            hold       <= '0;
            excess     <= 1'b0;
            search_req <= 1'b0;
        end else begin
            search_req <= 1'b0;
            if (sec_tick) begin
                hold   <= inc;
                live_q <= '0;
                excess <= 1'b0;
            end else begin
                live_q <= inc;
                if (reach && !excess) begin
                    excess     <= 1'b1;
                    search_req <= search_en;
                end
            end
        end
    end

endmodule

// File: rtl/e1_crc4_mon.sv
module e1_crc4_mon
    import e1c4_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int THRESH = 915
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_data,
    input  logic             smf_mark,
    input  logic             rem_mark,
    input  logic             sec_tick,
    input  logic             realign,
    input  logic             search_en,
    output logic             crc_chk,
    output logic             crc_err,
    output logic [CNT_W-1:0] err_hold,
    output logic             excess,
    output logic             search_req
);
    rx_bit_t  rx;
    crc_t     prev_crc;
    logic     prev_ok;
    cmp_evt_t evt;

    always_comb begin
        rx.vld       = rx_valid;
        rx.data      = rx_data;
        rx.smf_start = smf_mark;
        rx.rem_slot  = rem_mark;
    end

    e1c4_crc_engine u_crc (
        .clk      (clk),
        .rst      (rst),
        .rx       (rx),
        .realign  (realign),
        .prev_crc (prev_crc),
        .prev_ok  (prev_ok)
    );

    e1c4_rem_capture u_rem (
        .clk      (clk),
        .rst      (rst),
        .rx       (rx),
        .realign  (realign),
        .prev_crc (prev_crc),
        .prev_ok  (prev_ok),
        .evt      (evt)
    );

    e1c4_err_accum #(.CNT_W(CNT_W), .THRESH(THRESH)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .err_evt    (evt.mismatch),
        .sec_tick   (sec_tick),
        .search_en  (search_en),
        .hold       (err_hold),
        .excess     (excess),
        .search_req (search_req)
    );

    assign crc_chk = evt.fire;
    assign crc_err = evt.mismatch;

endmodule

// File: rtl/e1c4_chk.sv
module e1c4_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             sec_tick,
    input logic             realign,
    input logic             crc_chk,
    input logic             crc_err,
    input logic [CNT_W-1:0] err_hold,
    input logic             excess,
    input logic             search_req
);
    AST_ERR_NEEDS_CHK: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> crc_chk);                                   // R3
    AST_NO_CHK_AFTER_REALIGN: assert property (@(posedge clk) disable iff (rst)
        realign |=> !crc_chk);                                  // R4
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
        !sec_tick |=> $stable(err_hold));                       // R6
    AST_EXCESS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !excess);                                  // R8
    AST_SEARCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        search_req |=> !search_req);                            // R9
    AST_SEARCH_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        search_req |-> $rose(excess));                          // R9
endmodule

bind e1_crc4_mon e1c4_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .realign    (realign),
    .crc_chk    (crc_chk),
    .crc_err    (crc_err),
    .err_hold   (err_hold),
    .excess     (excess),
    .search_req (search_req)
);

// File: tb/e1_crc4_mon_tb.sv
module e1_crc4_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 4;
    localparam int TH  = 5;
    localparam int SMF = 32;
    localparam int SAT = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_data = 0, smf_mark = 0, rem_mark = 0;
    logic sec_tick = 0, realign = 0, search_en = 0;
    logic crc_chk, crc_err, excess, search_req;
    logic [CW-1:0] err_hold;

    int n_cmp = 0, n_bad = 0;
    int seen_chk = 0, seen_err = 0, seen_srch = 0;
    int exp_sec = 0, srch_base = 0;
    bit have_prev = 0;
    logic [3:0] last_crc = '0;

    e1_crc4_mon #(.CNT_W(CW), .THRESH(TH)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .smf_mark(smf_mark), .rem_mark(rem_mark), .sec_tick(sec_tick),
        .realign(realign), .search_en(search_en), .crc_chk(crc_chk),
        .crc_err(crc_err), .err_hold(err_hold), .excess(excess),
        .search_req(search_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (crc_chk)    seen_chk++;
        if (crc_err)    seen_err++;
        if (search_req) seen_srch++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    // R2 model: long division of M(x)*x^4 by x^4+x+1, slots forced to zero
    function automatic logic [3:0] ref_crc(input logic [SMF-1:0] pay);
        logic [SMF+3:0] v;
        v = '0;
        for (int i = 0; i < SMF; i++)
            v[SMF+3-i] = (i % 8 == 0) ? 1'b0 : pay[i];
        for (int j = SMF + 3; j >= 4; j--)
            if (v[j]) v[j -: 5] = v[j -: 5] ^ 5'b10011;
        return v[3:0];
    endfunction

    task automatic send_smf(input logic [SMF-1:0] pay, input logic [3:0] rem,
                            input bit gaps, input string req);
        int c0, e0;
        bit exp_c, exp_e;
        c0 = seen_chk; e0 = seen_err;
        for (int i = 0; i < SMF; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            smf_mark = (i == 0);
            rem_mark = (i % 8 == 0);
            rx_data  = (i % 8 == 0) ? rem[3 - i/8] : pay[i];
            if (gaps && (i % 3 == 1)) begin
                // R5: idle cycle with misleading content
                @(negedge clk);
                rx_valid = 1'b0;
                rx_data  = ~rx_data;
                rem_mark = 1'b1;
                smf_mark = (i == 4);
            end
        end
        @(negedge clk);
        rx_valid = 0; rem_mark = 0; smf_mark = 0; rx_data = 0;
        repeat (3) @(negedge clk);
        exp_c = have_prev;
        exp_e = have_prev && (rem != last_crc);
        check((seen_chk - c0) == int'(exp_c), {req, " crc_chk"}, seen_chk - c0, int'(exp_c));
        check((seen_err - e0) == int'(exp_e), {req, " crc_err"}, seen_err - e0, int'(exp_e));
        if (exp_e) exp_sec++;
        have_prev = 1;
        last_crc  = ref_crc(pay);
    endtask

    task automatic do_tick();
        int exp_hold;
        check(excess == (exp_sec >= TH), "R8 excess before tick", excess, int'(exp_sec >= TH));
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        exp_hold = (exp_sec > SAT) ? SAT : exp_sec;
        check(err_hold == exp_hold, "R6 R7 err_hold after tick", err_hold, exp_hold);
        check(excess == 1'b0, "R8 excess cleared", excess, 0);
        exp_sec = 0;
        srch_base = seen_srch;
    endtask

    task automatic do_realign();
        @(negedge clk); realign = 1'b1;
        @(negedge clk); realign = 1'b0;
        have_prev = 0;
    endtask

    initial begin
        logic [SMF-1:0] p;
        repeat (3) @(negedge clk);
        check({crc_chk, crc_err, excess, search_req} == 4'b0, "R1 pulses in reset",
              {crc_chk, crc_err, excess, search_req}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(err_hold == '0, "R1 err_hold after reset", err_hold, 0);
        check({crc_chk, crc_err, excess, search_req} == 4'b0, "R1 outputs after reset",
              {crc_chk, crc_err, excess, search_req}, 0);

        // second 1: search enabled
        search_en = 1'b1;
        send_smf(32'hA5C3_0F17, 4'h0, 0, "R4 first after reset");
        send_smf(32'h3C3C_9E01, last_crc, 1, "R2 R3 R5 correct with gaps");
        p = 32'h1234_5678;
        send_smf(p, last_crc, 0, "R3 lead-in");
        for (int r = 0; r < 16; r++)
            send_smf(p, 4'(r), (r % 2) == 1, "R3 remainder sweep");
        for (int k = 0; k < 3; k++)
            send_smf(p, ~last_crc, 0, "R7 extra errors");
        check(seen_srch - srch_base == 1, "R9 search pulses enabled", seen_srch - srch_base, 1);
        do_tick();

        // second 2: below threshold, hold steady before tick
        search_en = 1'b0;
        for (int k = 0; k < TH - 1; k++)
            send_smf(p, ~last_crc, 0, "R3 under threshold");
        check(err_hold == SAT, "R6 hold steady mid-interval", err_hold, SAT);
        check(seen_srch - srch_base == 0, "R9 no search below threshold", seen_srch - srch_base, 0);
        do_tick();

        // second 3: above threshold, search disabled
        for (int k = 0; k < TH + 1; k++)
            send_smf(p, ~last_crc, 0, "R3 over threshold");
        check(seen_srch - srch_base == 0, "R9 search disabled", seen_srch - srch_base, 0);
        do_tick();

        // realignment discards history
        do_realign();
        send_smf(32'hFFFF_0000, ~last_crc, 0, "R4 first after realign");
        send_smf(32'h0F0F_F0F0, last_crc, 1, "R4 compare resumes");

        // payload pattern sweep with correct remainders
        send_smf('0, last_crc, 0, "R2 all zeros");
        send_smf('1, last_crc, 0, "R2 all ones");
        send_smf(32'hAAAA_AAAA, last_crc, 1, "R2 alternating");
        for (int b = 0; b < SMF; b++)
            send_smf(32'h1 << b, last_crc, b % 2 == 0, "R2 walking one");
        do_tick();
        finish_run();
    end
endmodule